// File: doc/BRIEF.md
# Output Range Clamp

This block limits three 12-bit colour components of a streaming pixel to a legal range before the pixel leaves the display pipeline. Each component is compared with a lower and an upper bound. A component below the lower bound is replaced by that bound, and a component above the upper bound is replaced by that bound. Any other value is passed through unchanged.

The bounds depend on a 3-bit format selector. Three selector values pick a fixed limited-range window for 8, 10 or 12 bits per component. These windows apply to the MSB-aligned 12-bit value, so every preset is 0x100..0xEB0. One selector value uses six programmable bounds, a lower and upper pair for each component. All other values pass the data untouched. A global enable must be high for any clamping to happen.

The result is registered, and the valid flag is delayed by the same single cycle.

Top module: `range_clamp`

## Requirements
- R1: With `clamp_en` low, `pix_out` equals the `pix_in` of the previous cycle for every format code.
- R2: Format code 0 (6 bpc) passes data unchanged, even with `clamp_en` high.
- R3: Format codes 1, 2 and 3 (8, 10 and 12 bpc) clamp every component to 0x100..0xEB0 when enabled.
- R4: Format code 7 clamps each component to its own programmed pair of lower and upper bounds when enabled.
- R5: A component below its lower bound outputs the lower bound, and a component above its upper bound outputs the upper bound. Values inside the range, including both end values, are unchanged.
- R6: If a programmed lower bound exceeds its upper bound, the output for that component is the upper bound whenever the input exceeds the upper bound or lies below the lower bound.
- R7: Reserved codes 4, 5 and 6 behave like code 0.
- R8: `valid_out` equals `valid_in` delayed by one cycle. After reset, `valid_out` is 0.
- R9: The reset value of the bound ports is 0x010 lower and 0xFEF upper. This is a recommended setting; the block itself holds no bound state. With these bounds and code 7, an input of 0 outputs 0x010 and an input of 0xFFF outputs 0xFEF.

Pixel packing: `pix_in`/`pix_out` bits [35:24] = R, [23:12] = G, [11:0] = B. Bound ports use the same R, G, B packing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| valid_in | input | 1 | input pixel valid |
| pix_in | input | 36 | R,G,B components, 12 bits each |
| clamp_en | input | 1 | global clamp enable |
| fmt_code | input | 3 | format selector: 0 none, 1/2/3 presets, 7 programmable, 4-6 reserved |
| lo_bound | input | 36 | programmable lower bounds, R,G,B |
| hi_bound | input | 36 | programmable upper bounds, R,G,B |
| valid_out | output | 1 | registered valid |
| pix_out | output | 36 | registered clamped pixel |

## Verification
On every cycle, the assertions check the following:
- the one-cycle valid delay;
- that each output component lies inside the active window for preset codes;
- that the data is unchanged when clamping is off or the code is non-clamping;
- that the upper bound wins for inverted programmable pairs.

The exact saturation values at and around each boundary, the independence of the three components, and the behaviour of the reserved codes are shown by the bench sweeps.

// File: rtl/range_clamp_pkg.sv
package range_clamp_pkg;
  typedef enum logic [2:0] {
    FMT_NONE  = 3'd0,
    FMT_B8    = 3'd1,
    FMT_B10   = 3'd2,
    FMT_B12   = 3'd3,
    FMT_PROG  = 3'd7
  } fmt_e;

  function automatic logic fmt_is_preset(input logic [2:0] c);
    return (c == 3'd1) || (c == 3'd2) || (c == 3'd3);
  endfunction
endpackage

// File: rtl/range_clamp_decode.sv
module range_clamp_decode
  import range_clamp_pkg::*;
#(
  parameter int W     = 12,
  parameter int NCOMP = 3,
  parameter logic [W-1:0] PRE_LO = 12'h100,
  parameter logic [W-1:0] PRE_HI = 12'hEB0
) (
  input  logic                 clamp_en,
  input  logic [2:0]           fmt_code,
  input  logic [NCOMP*W-1:0]   lo_prog,
  input  logic [NCOMP*W-1:0]   hi_prog,
  output logic                 active,
  output logic [NCOMP*W-1:0]   lo_sel,
  output logic [NCOMP*W-1:0]   hi_sel
);
  logic preset;
  logic prog;

  always_comb begin
    preset = fmt_is_preset(fmt_code);
    prog   = (fmt_code == FMT_PROG);
    active = clamp_en && (preset || prog);
  end

  for (genvar i = 0; i < NCOMP; i++) begin : g_sel
    always_comb begin
      if (prog) begin
        lo_sel[i*W +: W] = lo_prog[i*W +: W];
        hi_sel[i*W +: W] = hi_prog[i*W +: W];
      end else begin
        lo_sel[i*W +: W] = PRE_LO;
        hi_sel[i*W +: W] = PRE_HI;
      end
    end
  end
endmodule

// File: rtl/range_clamp_lane.sv
module range_clamp_lane #(
  parameter int W = 12
) (
  input  logic         active,
  input  logic [W-1:0] din,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] dout
);
  always_comb begin
    if (!active)      dout = din;
    else if (din > hi) dout = hi;
    else if (din < lo) dout = (lo > hi) ? hi : lo;
    else               dout = din;
  end
endmodule

// File: rtl/range_clamp.sv
module range_clamp
  import range_clamp_pkg::*;
#(
  parameter int W     = 12,
  parameter int NCOMP = 3,
  localparam int PW   = NCOMP * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_in,
  input  logic [PW-1:0] pix_in,
  input  logic          clamp_en,
  input  logic [2:0]    fmt_code,
  input  logic [PW-1:0] lo_bound,
  input  logic [PW-1:0] hi_bound,
  output logic          valid_out,
  output logic [PW-1:0] pix_out
);
  logic          active;
  logic [PW-1:0] lo_sel, hi_sel, pix_next;

  range_clamp_decode #(.W(W), .NCOMP(NCOMP)) u_dec (
    .clamp_en (clamp_en),
    .fmt_code (fmt_code),
    .lo_prog  (lo_bound),
    .hi_prog  (hi_bound),
    .active   (active),
    .lo_sel   (lo_sel),
    .hi_sel   (hi_sel)
  );

  for (genvar i = 0; i < NCOMP; i++) begin : g_lane
    range_clamp_lane #(.W(W)) u_lane (
      .active (active),
      .din    (pix_in[i*W +: W]),
      .lo     (lo_sel[i*W +: W]),
      .hi     (hi_sel[i*W +: W]),
      .dout   (pix_next[i*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      pix_out   <= '0;
    end else begin
      valid_out <= valid_in;
      pix_out   <= pix_next;
    end
  end
endmodule

// File: rtl/range_clamp_checker.sv
module range_clamp_checker #(
  parameter int W = 12,
  parameter int NCOMP = 3,
  localparam int PW = NCOMP * W
) (
  input logic          clk,
  input logic          rst,
  input logic          valid_in,
  input logic [PW-1:0] pix_in,
  input logic          clamp_en,
  input logic [2:0]    fmt_code,
  input logic [PW-1:0] lo_bound,
  input logic [PW-1:0] hi_bound,
  input logic          valid_out,
  input logic [PW-1:0] pix_out
);
  logic started;
  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    started |-> (valid_out == $past(valid_in))); // R8

  AST_BYPASS_OFF: assert property (@(posedge clk) disable iff (rst)
    (started && $past(!clamp_en)) |-> (pix_out == $past(pix_in))); // R1

  AST_BYPASS_CODE: assert property (@(posedge clk) disable iff (rst)
    (started && ($past(fmt_code) == 3'd0 || ($past(fmt_code) >= 3'd4 && $past(fmt_code) <= 3'd6)))
      |-> (pix_out == $past(pix_in))); // R2 R7

  for (genvar i = 0; i < NCOMP; i++) begin : g_chk
    AST_PRESET_WINDOW: assert property (@(posedge clk) disable iff (rst)
      (started && $past(clamp_en) && $past(fmt_code) >= 3'd1 && $past(fmt_code) <= 3'd3)
        |-> (pix_out[i*W +: W] >= 12'h100 && pix_out[i*W +: W] <= 12'hEB0)); // R3

    AST_PROG_UPPER: assert property (@(posedge clk) disable iff (rst)
      (started && $past(clamp_en) && $past(fmt_code) == 3'd7)
        |-> (pix_out[i*W +: W] <= $past(hi_bound[i*W +: W]))); // R4 R6
  end
endmodule

bind range_clamp range_clamp_checker #(.W(W), .NCOMP(NCOMP)) u_chk (.*);

// File: tb/range_clamp_test.sv
module range_clamp_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int PW = 36;

  logic clk = 1'b0;
  logic rst;
  logic valid_in;
  logic [PW-1:0] pix_in;
  logic clamp_en;
  logic [2:0] fmt_code;
  logic [PW-1:0] lo_bound, hi_bound;
  logic valid_out;
  logic [PW-1:0] pix_out;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  range_clamp uut (.*);

  function automatic logic [W-1:0] model(input logic en, input logic [2:0] c,
      input logic [W-1:0] d, input logic [W-1:0] lo, input logic [W-1:0] hi);
    logic [W-1:0] l, h;
    if (!en) return d;
    if (c >= 3'd1 && c <= 3'd3) begin l = 12'h100; h = 12'hEB0; end
    else if (c == 3'd7) begin l = lo; h = hi; end
    else return d;
    if (d > h) return h;
    if (d < l) return (l > h) ? h : l;
    return d;
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one pixel, sample output after the registering edge
  task automatic apply(input string req, input logic en, input logic [2:0] c,
      input logic [PW-1:0] d);
    logic [PW-1:0] exp;
    clamp_en = en; fmt_code = c; pix_in = d; valid_in = 1'b1;
    for (int i = 0; i < 3; i++)
      exp[i*W +: W] = model(en, c, d[i*W +: W], lo_bound[i*W +: W], hi_bound[i*W +: W]);
    @(posedge clk); #1;
    check(req, pix_out, exp);
    check("R8", {35'd0, valid_out}, 36'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; valid_in = 0; pix_in = '0; clamp_en = 0; fmt_code = 0;
    lo_bound = {3{12'h010}}; hi_bound = {3{12'hFEF}};
    @(posedge clk); @(posedge clk); #1;
    check("R8 reset", {valid_out, pix_out}, 37'd0);
    rst = 1'b0;

    // R9 default bounds
    apply("R9", 1'b1, 3'd7, {12'h000, 12'hFFF, 12'h500});

    // sweep every code, enable, across value grid on all components
    for (int en = 0; en < 2; en++)
      for (int c = 0; c < 8; c++)
        for (int v = 0; v < 4096; v += 37)
          apply(en == 0 ? "R1" : (c == 0 ? "R2" : (c >= 4 && c <= 6 ? "R7" :
                (c == 7 ? "R4" : "R3"))), en[0], c[2:0],
                {v[11:0], 12'(4095 - v), 12'(v ^ 12'hA5A)});

    // R5 exact boundaries of preset window
    apply("R5", 1'b1, 3'd2, {12'h0FF, 12'h100, 12'h101});
    apply("R5", 1'b1, 3'd3, {12'hEAF, 12'hEB0, 12'hEB1});

    // R4 per-component independent bounds
    lo_bound = {12'h020, 12'h300, 12'h800};
    hi_bound = {12'h0F0, 12'h700, 12'hC00};
    for (int v = 0; v < 4096; v += 13)
      apply("R4", 1'b1, 3'd7, {3{v[11:0]}});

    // R6 inverted pair: upper wins
    lo_bound = {3{12'h900}};
    hi_bound = {3{12'h400}};
    apply("R6", 1'b1, 3'd7, {12'h100, 12'h600, 12'hA00});

    // R8 valid low propagates
    valid_in = 1'b0;
    @(posedge clk); #1;
    check("R8", {35'd0, valid_out}, 36'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule